// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block lets a host move bytes between a single data port and an on-block packet store without addressing each byte itself. The host loads a 16-bit transfer pointer and a 16-bit remaining-length counter, one byte-wide register write per half. Each data port beat then moves one, two or four bytes in little-endian lane order. After the beat the pointer advances, and it wraps from the ring stop page back to the ring start page. The counter goes down by the same amount. When the counter runs out, the block raises a transfer-complete status bit.

The block also keeps the interrupt status and interrupt mask registers and drives the interrupt line. Neighbouring receive and transmit logic can set the six low status bits through single-cycle event pulses. Register paging and the receive and transmit datapaths sit outside this block.

The data port uses a valid/ready handshake. A beat is taken on every rising edge where `dp_valid` and `dp_ready` are both high. `dp_ready` is held high, so the engine never applies back-pressure: every offered beat completes in one cycle. For a read beat, the read data is presented combinationally in the same cycle as `dp_valid`. The pointer and counter change at the edge that takes the beat.

Top module: `rdma_port_engine`

## Requirements
- R1: After reset, `int_status` is 0x80, the pointer and counter are 0, `irq` is low and `dp_ready` is high.
- R2: Register select codes are 1 for pointer low byte, 2 for pointer high byte, 3 for counter low byte and 4 for counter high byte. Each write replaces only its own byte and keeps the other half.
- R3: The beat size is 4 when `dp_wide` is high. Otherwise it is 2 when bit 0 of the data-config register (select 7) is set, and 1 when that bit is clear. Byte k of a beat sits in bits 8k+7:8k and belongs to address base+k.
- R4: After each beat the pointer becomes pointer+size, modulo 2^16. If that sum equals {stop page, 8'h00}, the pointer is loaded with {start page, 8'h00} instead. The start page is set with select 5 and the stop page with select 6.
- R5: If the counter is less than or equal to the beat size, the counter becomes 0 and status bit 6 is set. Otherwise the counter drops by the size.
- R6: A write beat taken while the counter is 0 changes neither the store, the pointer nor the counter. A read beat taken while the counter is 0 still advances the pointer and sets status bit 6.
- R7: A command write (select 0) with bit 0 clear clears status bit 7. If that write also has bit 3 or bit 4 set while the counter is 0, it sets status bit 6. A command write with bit 0 set does neither.
- R8: Two- and four-byte beats force the pointer even. A beat is accessible when its base address is below 32, or when it lies inside the window of WIN_BYTES bytes starting at WIN_BASE; a four-byte beat must end inside that window. An inaccessible read returns 0xFF in each active lane, and an inaccessible write leaves the store unchanged.
- R9: `irq` is high exactly when (status AND mask AND 0x7F) is nonzero. The mask is written with select 8. A write to select 9 clears each status bit written as 1 in bits 6:0 and never touches bit 7.
- R10: When a status bit is set and cleared in the same cycle, it ends up set. When a register byte write and a beat update the same pointer or counter byte in the same cycle, the register value wins for that byte, and the other byte takes the beat update.
- R11: A pulse on `ev_set[k]` sets status bit k, for k from 0 to 5.
- R12: Inactive upper lanes of `dp_rdata` read as 0. Read data is valid in the same cycle as the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 4 | Register select code |
| reg_wdata | input | 8 | Register write byte |
| ev_set | input | 6 | Status set pulses from neighbour logic |
| dp_valid | input | 1 | Data port beat valid |
| dp_ready | output | 1 | Data port ready (always high) |
| dp_write | input | 1 | Beat direction: 1 writes the store, 0 reads it |
| dp_wide | input | 1 | Four-byte beat |
| dp_wdata | input | 32 | Write beat data |
| dp_rdata | output | 32 | Read beat data |
| dma_addr | output | 16 | Current transfer pointer |
| dma_count | output | 16 | Remaining byte count |
| int_status | output | 8 | Interrupt status register |
| irq | output | 1 | Interrupt line |

## Verification
Two things can meet in one cycle: a transfer-complete event and a host write that clears the same status bit. The bench provokes this by issuing the last beat of a one-byte transfer together with a clear of bit 6, and it expects the bit to stay set. The same idea applies to the pointer and counter, where a register byte write lands in the cycle of a beat. In that case the bench expects the written byte and the updated other byte. Both cases are judged against a cycle-accurate arithmetic model of pointer, counter, status and store.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  typedef enum logic [3:0] {
    SEL_CMD        = 4'd0,
    SEL_ADDR_LO    = 4'd1,
    SEL_ADDR_HI    = 4'd2,
    SEL_CNT_LO     = 4'd3,
    SEL_CNT_HI     = 4'd4,
    SEL_RING_START = 4'd5,
    SEL_RING_STOP  = 4'd6,
    SEL_DATA_CFG   = 4'd7,
    SEL_INT_MASK   = 4'd8,
    SEL_INT_CLEAR  = 4'd9
  } reg_sel_e;

  localparam int CMD_HALT_BIT = 0;
  localparam int CMD_RD_BIT   = 3;
  localparam int CMD_WR_BIT   = 4;
  localparam int ST_DONE_BIT  = 6;
  localparam int ST_RST_BIT   = 7;

  function automatic logic [2:0] access_size(input logic wide, input logic word_mode);
    if (wide)           return 3'd4;
    else if (word_mode) return 3'd2;
    else                return 3'd1;
  endfunction

endpackage

// File: rtl/rdma_ptr.sv
module rdma_ptr
  import rdma_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [2:0]    step_size,
  input  logic [AW/2-1:0] ring_start,
  input  logic [AW/2-1:0] ring_stop,
  input  logic          reg_wr,
  input  reg_sel_e      sel,
  input  logic [AW/2-1:0] wdata,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] count,
  output logic          done
);
  localparam int HALF = AW / 2;

  logic [AW-1:0] sum, adv, na, nc, stop_addr, start_addr;
  logic          last, cnt_wr, addr_wr;

  always_comb begin
    stop_addr  = {ring_stop, {HALF{1'b0}}};
    start_addr = {ring_start, {HALF{1'b0}}};
    sum        = addr + AW'(step_size);
    adv        = (sum == stop_addr) ? start_addr : sum;
    last       = (count <= AW'(step_size));
    cnt_wr     = reg_wr && (sel == SEL_CNT_LO || sel == SEL_CNT_HI);
    addr_wr    = reg_wr && (sel == SEL_ADDR_LO || sel == SEL_ADDR_HI);
    na = addr;
    nc = count;
    if (step) begin
      na = adv;
      nc = last ? '0 : count - AW'(step_size);
    end
    if (reg_wr) begin
      case (sel)
        SEL_ADDR_LO: na[HALF-1:0]  = wdata;
        SEL_ADDR_HI: na[AW-1:HALF] = wdata;
        SEL_CNT_LO:  nc[HALF-1:0]  = wdata;
        SEL_CNT_HI:  nc[AW-1:HALF] = wdata;
        default: ;
      endcase
    end
  end

  assign done = step && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr  <= '0;
      count <= '0;
    end else begin
      addr  <= na;
      count <= nc;
    end
  end

  // R5: the final beat leaves nothing to move
  assert_count_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last && !cnt_wr) |=> (count == '0));

  // R4: pointer advances by the beat size unless it meets the stop page
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !addr_wr && (sum != stop_addr)) |=> (addr == $past(addr) + AW'($past(step_size))));

  assert_addr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !addr_wr && (sum == stop_addr)) |=> (addr[HALF-1:0] == '0));

endmodule

// File: rtl/rdma_irq.sv
module rdma_irq
  import rdma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mask_wr,
  input  logic [6:0] mask_val,
  input  logic       clr_wr,
  input  logic [6:0] clr_val,
  input  logic       done_set,
  input  logic       cmd_wr,
  input  logic       cmd_halt,
  input  logic       cmd_remote,
  input  logic       count_zero,
  input  logic [5:0] ev_set,
  output logic [7:0] status,
  output logic       irq
);
  logic [6:0] mask;
  logic [7:0] set_v, clr_v;
  logic       cmd_zero;

  always_comb begin
    cmd_zero = cmd_wr && !cmd_halt && cmd_remote && count_zero;
    set_v    = {1'b0, (done_set || cmd_zero), ev_set};
    clr_v    = '0;
    if (clr_wr)              clr_v[6:0]         = clr_val;
    if (cmd_wr && !cmd_halt) clr_v[ST_RST_BIT]  = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 8'h80;
      mask   <= '0;
    end else begin
      status <= (status & ~clr_v) | set_v;
      if (mask_wr) mask <= mask_val;
    end
  end

  assign irq = |(status[6:0] & mask);

  // R10: a completion is never lost to a same-cycle clear
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> status[ST_DONE_BIT]);

  // R9: the reset-complete bit is only ever set by reset
  assert_rst_bit_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(status[ST_RST_BIT]));

  // R9: a clear write removes a bit that nothing sets in that cycle
  assert_clear_bit0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_val[0] && !ev_set[0]) |=> !status[0]);

endmodule

// File: rtl/rdma_mem.sv
module rdma_mem
  import rdma_pkg::*;
#(
  parameter int LOW_BYTES = 32,
  parameter int WIN_BASE  = 'h4000,
  parameter int WIN_BYTES = 256
) (
  input  logic        clk,
  input  logic [15:0] addr,
  input  logic        wide,
  input  logic        word_mode,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata
);
  localparam int DEPTH   = LOW_BYTES + WIN_BYTES;
  localparam int IW      = $clog2(DEPTH);
  localparam int WIN_END = WIN_BASE + WIN_BYTES;
  localparam int LANES   = 4;

  logic [7:0]    mem [DEPTH];
  logic [15:0]   ea;
  logic [2:0]    nbytes;
  logic          base_ok;
  logic [LANES-1:0] lane_on, lane_ok;
  logic [IW-1:0] lane_idx [LANES];

  always_comb begin
    ea      = (wide || word_mode) ? {addr[15:1], 1'b0} : addr;
    nbytes  = access_size(wide, word_mode);
    base_ok = (int'(ea) < LOW_BYTES) ||
              ((int'(ea) >= WIN_BASE) && (int'(ea) + (wide ? 4 : 1) <= WIN_END));
    for (int l = 0; l < LANES; l++) begin
      int la;
      la         = int'(ea) + l;
      lane_on[l] = (l < int'(nbytes));
      if (la < LOW_BYTES) begin
        lane_ok[l]  = base_ok;
        lane_idx[l] = IW'(la);
      end else if (la >= WIN_BASE && la < WIN_END) begin
        lane_ok[l]  = base_ok;
        lane_idx[l] = IW'(la - WIN_BASE + LOW_BYTES);
      end else begin
        lane_ok[l]  = 1'b0;
        lane_idx[l] = '0;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rdata[8*g +: 8] = !lane_on[g] ? 8'h00 :
                             lane_ok[g]  ? mem[lane_idx[g]] : 8'hFF;
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_en && lane_on[l] && lane_ok[l]) mem[lane_idx[l]] <= wdata[8*l +: 8];
    end
  end

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int LOW_BYTES = 32,
  parameter int WIN_BASE  = 'h4000,
  parameter int WIN_BYTES = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [3:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  input  logic [5:0]  ev_set,
  input  logic        dp_valid,
  output logic        dp_ready,
  input  logic        dp_write,
  input  logic        dp_wide,
  input  logic [31:0] dp_wdata,
  output logic [31:0] dp_rdata,
  output logic [15:0] dma_addr,
  output logic [15:0] dma_count,
  output logic [7:0]  int_status,
  output logic        irq
);
  reg_sel_e    sel;
  logic        word_mode;
  logic [7:0]  ring_start, ring_stop;
  logic        fire, cnt_zero, step, mem_we, done;
  logic [2:0]  size;

  assign sel      = reg_sel_e'(reg_sel);
  assign dp_ready = 1'b1;
  assign fire     = dp_valid && dp_ready;
  assign cnt_zero = (dma_count == '0);
  assign step     = fire && (!dp_write || !cnt_zero);
  assign mem_we   = fire && dp_write && !cnt_zero;
  assign size     = access_size(dp_wide, word_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_mode  <= 1'b0;
      ring_start <= '0;
      ring_stop  <= '0;
    end else if (reg_wr) begin
      case (sel)
        SEL_DATA_CFG:   word_mode  <= reg_wdata[0];
        SEL_RING_START: ring_start <= reg_wdata;
        SEL_RING_STOP:  ring_stop  <= reg_wdata;
        default: ;
      endcase
    end
  end

  rdma_ptr #(.AW(16)) u_ptr (
    .clk(clk), .rst_n(rst_n), .step(step), .step_size(size),
    .ring_start(ring_start), .ring_stop(ring_stop),
    .reg_wr(reg_wr), .sel(sel), .wdata(reg_wdata),
    .addr(dma_addr), .count(dma_count), .done(done)
  );

  rdma_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .mask_wr(reg_wr && sel == SEL_INT_MASK), .mask_val(reg_wdata[6:0]),
    .clr_wr(reg_wr && sel == SEL_INT_CLEAR), .clr_val(reg_wdata[6:0]),
    .done_set(done),
    .cmd_wr(reg_wr && sel == SEL_CMD),
    .cmd_halt(reg_wdata[CMD_HALT_BIT]),
    .cmd_remote(reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]),
    .count_zero(cnt_zero), .ev_set(ev_set),
    .status(int_status), .irq(irq)
  );

  rdma_mem #(.LOW_BYTES(LOW_BYTES), .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)) u_mem (
    .clk(clk), .addr(dma_addr), .wide(dp_wide), .word_mode(word_mode),
    .wr_en(mem_we), .wdata(dp_wdata), .rdata(dp_rdata)
  );

  // R6: a write beat against an empty counter leaves the pointer state alone
  assert_zero_write_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dp_write && cnt_zero && !reg_wr) |=> ($stable(dma_addr) && $stable(dma_count)));

  // R12: the port never back-pressures
  assert_ready_high_R12: assert property (@(posedge clk) disable iff (!rst_n) dp_ready);

endmodule

// File: tb/rdma_port_engine_test.sv
`timescale 1ns/1ps
module rdma_port_engine_test;
  localparam int WB = 'h4000;
  localparam int WE = 'h4100;
  localparam logic [3:0] S_CMD = 0, S_ALO = 1, S_AHI = 2, S_CLO = 3, S_CHI = 4,
                         S_RST = 5, S_RSP = 6, S_CFG = 7, S_MSK = 8, S_CLR = 9;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [3:0] reg_sel = 0; logic [7:0] reg_wdata = 0;
  logic [5:0] ev_set = 0;
  logic dp_valid = 0, dp_write = 0, dp_wide = 0; logic [31:0] dp_wdata = 0;
  wire dp_ready, irq; wire [31:0] dp_rdata; wire [15:0] dma_addr, dma_count; wire [7:0] int_status;

  int total = 0, bad = 0; bit finished = 0;

  int m_addr, m_cnt, m_stat, m_mask, m_dcfg, m_start, m_stop;
  logic [7:0] mm [288];

  always #2.5 clk = ~clk;

  rdma_port_engine uut (.clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .ev_set,
    .dp_valid, .dp_ready, .dp_write, .dp_wide, .dp_wdata, .dp_rdata,
    .dma_addr, .dma_count, .int_status, .irq);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic int midx(input int a);
    if (a < 32) return a;
    if (a >= WB && a < WE) return a - WB + 32;
    return -1;
  endfunction

  function automatic int bsize(input bit wide);
    return wide ? 4 : (m_dcfg[0] ? 2 : 1);
  endfunction

  function automatic bit base_ok(input int ea, input bit wide);
    return (ea < 32) || (ea >= WB && ea + (wide ? 4 : 1) <= WE);
  endfunction

  function automatic int eff(input bit wide);
    return (wide || m_dcfg[0]) ? (m_addr & 'hFFFE) : m_addr;
  endfunction

  function automatic logic [31:0] mread(input bit wide);
    logic [31:0] r = 0;
    int ea = eff(wide);
    for (int l = 0; l < bsize(wide); l++) begin
      int id = midx(ea + l);
      r[8*l +: 8] = (base_ok(ea, wide) && id >= 0) ? mm[id] : 8'hFF;
    end
    return r;
  endfunction

  task automatic mwrite(input bit wide, input logic [31:0] d);
    int ea = eff(wide);
    for (int l = 0; l < bsize(wide); l++) begin
      int id = midx(ea + l);
      if (base_ok(ea, wide) && id >= 0) mm[id] = d[8*l +: 8];
    end
  endtask

  // one cycle: optional beat, optional register write, optional events
  task automatic cyc(input bit acc, input bit wr, input bit wide, input logic [31:0] wd,
                     input bit rg, input logic [3:0] sel, input logic [7:0] rv,
                     input logic [5:0] ev, input string tag);
    int sz, sets, clr, na, nc;
    @(negedge clk);
    dp_valid = acc; dp_write = wr; dp_wide = wide; dp_wdata = wd;
    reg_wr = rg; reg_sel = sel; reg_wdata = rv; ev_set = ev;
    #0.5;
    if (acc && !wr) chk({tag, " R3 R8 R12 rdata"}, dp_rdata, mread(wide));
    if (acc) chk("R12 ready", {31'b0, dp_ready}, 1);
    sz = bsize(wide); sets = ev; clr = 0; na = m_addr; nc = m_cnt;
    if (acc && (!wr || m_cnt != 0)) begin
      if (wr) mwrite(wide, wd);
      na = (m_addr + sz) & 'hFFFF;
      if (na == (m_stop << 8)) na = m_start << 8;
      if (m_cnt <= sz) begin nc = 0; sets |= 'h40; end
      else nc = m_cnt - sz;
    end
    if (rg) begin
      case (sel)
        S_CMD: if (!rv[0]) begin
                 clr |= 'h80;
                 if ((rv[3] || rv[4]) && m_cnt == 0) sets |= 'h40;
               end
        S_ALO: na = (na & 'hFF00) | rv;
        S_AHI: na = (na & 'h00FF) | (int'(rv) << 8);
        S_CLO: nc = (nc & 'hFF00) | rv;
        S_CHI: nc = (nc & 'h00FF) | (int'(rv) << 8);
        S_RST: m_start = rv;
        S_RSP: m_stop = rv;
        S_CFG: m_dcfg = rv;
        S_MSK: m_mask = rv;
        S_CLR: clr |= rv & 'h7F;
        default: ;
      endcase
    end
    m_addr = na; m_cnt = nc;
    m_stat = (m_stat & ~clr) | sets;
    @(posedge clk); #0.5;
    dp_valid = 0; reg_wr = 0; ev_set = 0;
    chk({tag, " R2 R4 addr"}, dma_addr, m_addr);
    chk({tag, " R5 count"}, dma_count, m_cnt);
    chk({tag, " R7 R10 R11 status"}, int_status, m_stat);
    chk({tag, " R9 irq"}, irq, ((m_stat & m_mask & 'h7F) != 0));
  endtask

  task automatic rw(input logic [3:0] sel, input logic [7:0] v, input string tag);
    cyc(0, 0, 0, 0, 1, sel, v, 0, tag);
  endtask

  task automatic beat(input bit wr, input bit wide, input logic [31:0] d, input string tag);
    cyc(1, wr, wide, d, 0, 0, 0, 0, tag);
  endtask

  task automatic setup(input int a, input int c);
    rw(S_ALO, a[7:0], "R2"); rw(S_AHI, a[15:8], "R2");
    rw(S_CLO, c[7:0], "R2"); rw(S_CHI, c[15:8], "R2");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_addr = 0; m_cnt = 0; m_stat = 'h80; m_mask = 0; m_dcfg = 0; m_start = 0; m_stop = 0;
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1;
    // R1 reset state
    chk("R1 status", int_status, 8'h80);
    chk("R1 addr", dma_addr, 0);
    chk("R1 count", dma_count, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ready", dp_ready, 1);

    // R2 halves kept
    rw(S_ALO, 8'h34, "R2 lo"); rw(S_AHI, 8'h12, "R2 hi"); rw(S_ALO, 8'hAB, "R2 relo");
    rw(S_CLO, 8'h78, "R2 clo"); rw(S_CHI, 8'h56, "R2 chi"); rw(S_CHI, 8'h01, "R2 rechi");

    rw(S_RST, 8'h40, "R4 start"); rw(S_RSP, 8'h41, "R4 stop");
    // fill both regions with byte writes; window fill ends with a ring wrap
    setup(0, 32);
    for (int i = 0; i < 32; i++) beat(1, 0, i * 7 + 3, "R3 fill low");
    setup(WB, 256);
    for (int i = 0; i < 256; i++) beat(1, 0, (i ^ 'h5A) & 'hFF, "R4 R5 fill win");
    rw(S_CLR, 8'h40, "R9 clr");

    // sweep: size mode x start address x count, mixed reads and writes
    for (int mode = 0; mode < 3; mode++) begin
      rw(S_CFG, (mode == 1) ? 8'h01 : 8'h00, "R3 cfg");
      for (int k = 0; k < 6; k++) begin
        for (int c = 1; c < 10; c++) begin
          int a = (k < 3) ? ('h10 + k * 7) : ('h40F9 + k);
          int n = 0;
          setup(a, c);
          while (m_cnt != 0 && n < 12) begin
            beat((c + k + n) & 1, mode == 2, 32'hA5000000 + (mode << 16) + (k << 8) + c + n,
                 "R3 R4 R5 R8 sweep");
            n++;
          end
          rw(S_CLR, 8'h40, "R9 clr");
        end
      end
    end

    // R8 wide write straddling the window end is dropped as a whole
    rw(S_CFG, 0, "R3 cfg");
    setup('h40FE, 8);
    beat(1, 1, 32'h11223344, "R8 drop");
    setup('h40FE, 8);
    beat(0, 0, 0, "R8 keep FE"); beat(0, 0, 0, "R8 keep FF");
    setup('h0100, 4);
    beat(0, 0, 0, "R8 oor byte"); beat(0, 1, 0, "R8 oor wide");
    rw(S_CLR, 8'h7F, "R9 clr");

    // R6 zero count: write dropped, read still moves
    setup('h4010, 0);
    beat(1, 0, 8'hEE, "R6 drop");
    beat(0, 0, 0, "R6 read zero");
    rw(S_CLR, 8'h40, "R9 clr");

    // R9 R11 exhaustive mask sweep with events pending
    cyc(0, 0, 0, 0, 0, 0, 0, 6'h15, "R11 ev");
    cyc(0, 0, 0, 0, 0, 0, 0, 6'h22, "R11 ev");
    for (int m = 0; m < 256; m++) rw(S_MSK, m[7:0], "R9 mask");
    rw(S_CLR, 8'hFF, "R9 clear keeps bit7");
    rw(S_MSK, 8'hFF, "R9 mask");

    // R7 command paths
    setup('h4000, 0);
    rw(S_CMD, 8'h09, "R7 halted");
    rw(S_CMD, 8'h08, "R7 zero read");
    rw(S_CLR, 8'h40, "R9 clr");
    rw(S_CMD, 8'h10, "R7 zero write");
    rw(S_CLR, 8'h40, "R9 clr");
    setup('h4000, 5);
    rw(S_CMD, 8'h10, "R7 nonzero");
    rw(S_CMD, 8'h20, "R7 no remote");

    // R10 same-cycle collisions
    setup('h40FF, 5);
    cyc(1, 0, 0, 0, 1, S_ALO, 8'h77, 0, "R10 addr lo");
    cyc(1, 0, 0, 0, 1, S_CHI, 8'h02, 0, "R10 cnt hi");
    setup('h4020, 1);
    beat(0, 0, 0, "R10 set");
    setup('h4020, 1);
    cyc(1, 0, 0, 0, 1, S_CLR, 8'h40, 0, "R10 set wins");
    cyc(0, 0, 0, 0, 1, S_CLR, 8'h40, 6'h01, "R10 ev wins");
    rw(S_CLR, 8'h41, "R9 clr");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule